// File: doc/BRIEF.md
# Instruction Prefix Attribute Tracker

This block sits in the decode stage. It watches the stream of decoded instructions and recognises short prefix instructions that set two attributes for later instructions: the operand data size and the vector mask register. It then tags each ordinary instruction with the size and mask that apply to it. A fixed-width instruction set can therefore gain sized and masked operations without growing its instruction word.

A prefix comes in two forms. A persistent prefix replaces the default attributes for every instruction after it, until another persistent prefix arrives. A single-use prefix applies only to the next ordinary instruction. After that instruction, the persistent defaults apply again. A pipeline flush throws away any single-use prefix that is still waiting. It does not touch the persistent defaults.

A prefix is a compressed 16-bit instruction with a reserved 5-bit opcode. The size code uses 2 bits: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. The mask selector uses 3 bits, and the value 0 means unmasked. Each attribute beat is registered and appears one cycle after the instruction it describes.

Top module: `pfx_tracker`

## Requirements
- R1: After reset, the persistent attributes are size code 11 (64 bits) and mask 0, so the first ordinary instruction is tagged size 11, mask 0.
- R2: A decode word is a prefix only when decCompressed is 1 and decWord[15:11] equals PREFIX_OP (default 5'b10111). In a prefix, bit 10 selects the form (1 = persistent, 0 = single-use), bits 9:8 carry the size code and bits 7:5 carry the mask.
- R3: A prefix produces no attribute beat. The cycle after a prefix is accepted, attrValid is 0.
- R4: A valid, unflushed, ordinary instruction produces exactly one beat: attrValid is 1 in the following cycle, with that instruction's attributes. When no instruction is accepted, attrValid is 0.
- R5: A persistent prefix sets the size and mask used by every later ordinary instruction, until another persistent prefix arrives.
- R6: A single-use prefix applies to the next ordinary instruction only, even across idle cycles. The persistent attributes apply after it.
- R7: When a second single-use prefix arrives before any ordinary instruction, it replaces the first.
- R8: A persistent prefix that arrives while a single-use prefix is pending does not cancel it. The next ordinary instruction still takes the single-use attributes.
- R9: flush discards a pending single-use prefix and keeps the persistent attributes. A decode word presented in the same cycle as flush is ignored.
- R10: A non-compressed word whose bits 15:11 match the prefix opcode is an ordinary instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline redirect; drops a pending single-use prefix and the current word |
| decValid | input | 1 | A decoded instruction is present this cycle |
| decCompressed | input | 1 | The present instruction is a 16-bit compressed form |
| decWord | input | 16 | Low halfword of the present instruction |
| attrValid | output | 1 | Attribute beat for the instruction accepted in the previous cycle |
| attrSize | output | 2 | Effective size code |
| attrMask | output | 3 | Effective mask register, 0 = unmasked |

## Verification
The bench goes after the timing interactions between the two prefix forms. It checks that a single-use prefix survives idle cycles and a persistent prefix placed after it, but does not survive a second ordinary instruction. A design that cleared the pending prefix on any later prefix, or never cleared it, would tag the wrong instruction. The bench drives a flush in the same cycle as a word and after a pending single-use prefix. A design that let either through would emit a stray beat or stale attributes. It also sends prefix-shaped words in the non-compressed form; a design that ignored the compressed flag would swallow real instructions. Randomised streams cover overlaps that the directed cases miss.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int SIZE_W = 2;
  localparam int MASK_W = 3;
  localparam int OP_W   = 5;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic [MASK_W-1:0] mask;
  } pfxAttr_t;

  typedef struct packed {
    logic loadSticky;
    logic loadShot;
    logic dropShot;
    logic emit;
  } pfxStrobes_t;
endpackage

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
#(
  parameter logic [OP_W-1:0] PREFIX_OP = 5'b10111
) (
  input  logic              flush,
  input  logic              decValid,
  input  logic              decCompressed,
  input  logic [WORD_W-1:0] decWord,
  output pfxStrobes_t       strobes,
  output pfxAttr_t          fieldAttr
);
  localparam int OP_LSB    = WORD_W - OP_W;
  localparam int FORM_BIT  = OP_LSB - 1;
  localparam int SIZE_LSB  = FORM_BIT - SIZE_W;
  localparam int MASK_LSB  = SIZE_LSB - MASK_W;

  logic isPrefix;
  logic live;

  always_comb begin
    isPrefix = decCompressed && (decWord[WORD_W-1:OP_LSB] == PREFIX_OP);
    live     = decValid && !flush;
    fieldAttr.size = decWord[SIZE_LSB +: SIZE_W];
    fieldAttr.mask = decWord[MASK_LSB +: MASK_W];
    strobes.loadSticky = live && isPrefix && decWord[FORM_BIT];
    strobes.loadShot   = live && isPrefix && !decWord[FORM_BIT];
    strobes.emit       = live && !isPrefix;
    strobes.dropShot   = flush || strobes.emit;
  end
endmodule

// File: rtl/pfx_datapath.sv
module pfx_datapath
  import pfx_pkg::*;
#(
  parameter logic [SIZE_W-1:0] DEFAULT_SIZE = 2'b11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pfxStrobes_t strobes,
  input  pfxAttr_t    fieldAttr,
  output logic        outValid,
  output pfxAttr_t    outAttr
);
  pfxAttr_t stickyAttr;
  pfxAttr_t shotAttr;
  logic     shotPending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stickyAttr  <= '{size: DEFAULT_SIZE, mask: '0};
      shotAttr    <= '0;
      shotPending <= 1'b0;
      outValid    <= 1'b0;
      outAttr     <= '{size: DEFAULT_SIZE, mask: '0};
    end else begin
      if (strobes.loadSticky) stickyAttr <= fieldAttr;
      if (strobes.loadShot) begin
        shotAttr    <= fieldAttr;
        shotPending <= 1'b1;
      end else if (strobes.dropShot) begin
        shotPending <= 1'b0;
      end
      outValid <= strobes.emit;
      if (strobes.emit) outAttr <= shotPending ? shotAttr : stickyAttr;
    end
  end
endmodule

// File: rtl/pfx_tracker.sv
module pfx_tracker
  import pfx_pkg::*;
#(
  parameter logic [OP_W-1:0]   PREFIX_OP    = 5'b10111,
  parameter logic [SIZE_W-1:0] DEFAULT_SIZE = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              decValid,
  input  logic              decCompressed,
  input  logic [WORD_W-1:0] decWord,
  output logic              attrValid,
  output logic [SIZE_W-1:0] attrSize,
  output logic [MASK_W-1:0] attrMask
);
  pfxStrobes_t strobes;
  pfxAttr_t    fieldAttr;
  pfxAttr_t    outAttr;

  pfx_ctrl #(.PREFIX_OP(PREFIX_OP)) u_ctrl (
    .flush(flush), .decValid(decValid), .decCompressed(decCompressed),
    .decWord(decWord), .strobes(strobes), .fieldAttr(fieldAttr)
  );

  pfx_datapath #(.DEFAULT_SIZE(DEFAULT_SIZE)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .fieldAttr(fieldAttr),
    .outValid(attrValid), .outAttr(outAttr)
  );

  assign attrSize = outAttr.size;
  assign attrMask = outAttr.mask;
endmodule

// File: rtl/pfx_tracker_chk.sv
module pfx_tracker_chk
  import pfx_pkg::*;
#(
  parameter logic [OP_W-1:0] PREFIX_OP = 5'b10111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              decValid,
  input logic              decCompressed,
  input logic [WORD_W-1:0] decWord,
  input logic              attrValid
);
  logic seenPfx;
  assign seenPfx = decCompressed && (decWord[WORD_W-1 -: OP_W] == PREFIX_OP);

  // R3: an accepted prefix yields no beat
  a_r3_prefix_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && !flush && seenPfx) |=> !attrValid);

  // R4: accepted ordinary instruction yields a beat next cycle
  a_r4_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && !flush && !seenPfx) |=> attrValid);

  // R4: a beat always traces back to an accepted instruction
  a_r4_beat_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    attrValid |-> $past(decValid && !flush));

  // R9: a word in a flush cycle is dropped
  a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !attrValid);
endmodule

bind pfx_tracker pfx_tracker_chk #(.PREFIX_OP(PREFIX_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .decValid(decValid),
  .decCompressed(decCompressed), .decWord(decWord), .attrValid(attrValid)
);

// File: tb/pfx_tracker_tb.sv
module pfx_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] OP = 5'b10111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic decValid = 1'b0;
  logic decCompressed = 1'b0;
  logic [15:0] decWord = '0;
  logic attrValid;
  logic [1:0] attrSize;
  logic [2:0] attrMask;

  int nTests = 0;
  int nFail  = 0;

  logic [1:0] mStSize = 2'b11;
  logic [2:0] mStMask = 3'd0;
  logic       mShV    = 1'b0;
  logic [1:0] mShSize = 2'b00;
  logic [2:0] mShMask = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .decValid(decValid),
    .decCompressed(decCompressed), .decWord(decWord),
    .attrValid(attrValid), .attrSize(attrSize), .attrMask(attrMask)
  );

  function automatic logic [15:0] mkPfx(input logic sticky, input logic [1:0] sz,
                                        input logic [2:0] mk);
    return {OP, sticky, sz, mk, 5'b0};
  endfunction

  function automatic logic isPfxWord(input logic comp, input logic [15:0] w);
    return comp && (w[15:11] == OP);
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, update the reference model, compare the registered beat.
  task automatic step(input string tag, input logic v, input logic comp,
                      input logic [15:0] w, input logic fl);
    logic expV;
    logic [1:0] expS;
    logic [2:0] expM;
    expV = 1'b0; expS = 2'b0; expM = 3'b0;
    decValid = v; decCompressed = comp; decWord = w; flush = fl;
    if (fl) begin
      mShV = 1'b0;
    end else if (v && isPfxWord(comp, w)) begin
      if (w[10]) begin mStSize = w[9:8]; mStMask = w[7:5]; end
      else begin mShV = 1'b1; mShSize = w[9:8]; mShMask = w[7:5]; end
    end else if (v) begin
      expV = 1'b1;
      expS = mShV ? mShSize : mStSize;
      expM = mShV ? mShMask : mStMask;
      mShV = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    decValid = 1'b0; flush = 1'b0;
    if (expV) check(tag, {attrValid, attrSize, attrMask}, {expV, expS, expM});
    else check(tag, {attrValid, 5'b0}, 6'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset beat", {attrValid, attrSize, attrMask}, {1'b0, 2'b11, 3'd0});
    rst_n = 1'b1;
    // R1: first instruction takes the reset defaults
    step("R1 default attrs", 1, 0, 16'h1234, 0);
    // R2/R3: persistent prefix, no beat
    step("R3 sticky no beat", 1, 1, mkPfx(1, 2'b01, 3'd5), 0);
    // R5: persists across several instructions
    step("R5 sticky first", 1, 1, 16'h0042, 0);
    step("R5 sticky second", 1, 0, 16'hABCD, 0);
    // R6: single-use across idle cycles
    step("R3 oneshot no beat", 1, 1, mkPfx(0, 2'b00, 3'd2), 0);
    step("R6 idle", 0, 0, 16'h0, 0);
    step("R6 idle", 0, 0, 16'h0, 0);
    step("R6 oneshot applied", 1, 0, 16'h5555, 0);
    step("R6 sticky restored", 1, 0, 16'h5556, 0);
    // R7: later single-use replaces earlier
    step("R7 first oneshot", 1, 1, mkPfx(0, 2'b10, 3'd1), 0);
    step("R7 second oneshot", 1, 1, mkPfx(0, 2'b00, 3'd7), 0);
    step("R7 later wins", 1, 0, 16'h0001, 0);
    // R8: persistent after pending single-use
    step("R8 oneshot", 1, 1, mkPfx(0, 2'b10, 3'd3), 0);
    step("R8 sticky", 1, 1, mkPfx(1, 2'b11, 3'd4), 0);
    step("R8 oneshot kept", 1, 0, 16'h0002, 0);
    step("R8 new sticky", 1, 0, 16'h0003, 0);
    // R9: flush drops pending single-use and same-cycle word
    step("R9 oneshot", 1, 1, mkPfx(0, 2'b01, 3'd6), 0);
    step("R9 flush with word", 1, 0, 16'h0004, 1);
    step("R9 sticky kept", 1, 0, 16'h0005, 0);
    step("R9 flushed sticky prefix", 1, 1, mkPfx(1, 2'b00, 3'd1), 1);
    step("R9 sticky unchanged", 1, 0, 16'h0006, 0);
    // R10: non-compressed prefix-shaped word is ordinary
    step("R10 wide word beat", 1, 0, mkPfx(1, 2'b00, 3'd2), 0);
    step("R10 sticky unchanged", 1, 0, 16'h0007, 0);
    // Random mix: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 3000; i++) begin
      logic v, c, f, p;
      logic [15:0] w;
      v = ($urandom % 4) != 0;
      f = ($urandom % 12) == 0;
      p = ($urandom % 5) < 2;
      c = ($urandom % 2) == 1;
      w = 16'($urandom);
      if (p) begin c = 1'b1; w = mkPfx(1'($urandom), 2'($urandom), 3'($urandom)); end
      step("R4 random stream", v, c, w, f);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule